// File: doc/BRIEF.md
# Configurable GPIO Pin Drive Controller

This block holds the drive configuration of one 8-pin I/O port and turns it into per-pin transistor enables. For each pin, two mode bits select quasi-bidirectional, push-pull, high-impedance input, or open-drain operation. The block combines the selected mode with the port's output latch and a synchronized copy of the pin level. From these it drives four enables per pin: a pull-down, a strong pull-up, a weak pull-up and a very-weak pull-up. The CPU writes the latch and the two mode registers through a one-cycle write strobe. It reads the pin levels back through a synchronizer.

In quasi-bidirectional mode the pull-ups are gated separately. The very-weak pull-up follows the latch. The weak pull-up also needs the pin to read high. A latch change from 0 to 1 adds a short burst of strong pull-up to speed up the rising edge. Some pins are restricted by parameter masks. One pin is always a high-impedance input. Two pins can only be inputs or open-drain outputs.

Top module: `gpio_drive_ctrl`

## Requirements
- R1: After reset the latch reads all ones, the high mode bits read all ones and the low mode bits all zeros, so every pin is a high-impedance input with all four enables low and pin_rd zero.
- R2: A write with wr_en high takes effect at the next clock edge. wr_sel selects the target: 0 is the latch, 1 is the high mode bits, 2 is the low mode bits, 3 writes nothing. The mode code {high,low} means 00 quasi-bidirectional, 01 push-pull, 10 high-impedance input, 11 open drain.
- R3: In quasi-bidirectional mode the pull-down is on exactly when the latch is 0, and the very-weak pull-up is on exactly when the latch is 1.
- R4: In quasi-bidirectional mode the weak pull-up is on only when the latch is 1 and the synchronized pin level is 1.
- R5: In quasi-bidirectional mode, a latch write that takes a bit from 0 to 1 turns that pin's strong pull-up on for exactly the two cycles after the write edge. No other event starts it.
- R6: A running strong pull-up burst stops at the next edge if a write leaves the pin in any mode other than quasi-bidirectional, or clears its latch bit.
- R7: In push-pull mode the strong pull-up equals the latch and the pull-down equals its inverse, with the weak and very-weak pull-ups off.
- R8: In open-drain mode only the pull-down is used, on when the latch is 0. In high-impedance mode all four enables are off.
- R9: Pin 5 (HIZ_ONLY_MASK) is a high-impedance input whatever its mode bits hold.
- R10: On pins 2 and 3 (OD_ONLY_MASK) the high mode bit is taken as 1, so code 00 gives a high-impedance input and 01 gives open drain.
- R11: pin_rd shows the pin level sampled through two flops. A change on pin_in appears on pin_rd, and in the weak pull-up decision, two edges later.
- R12: The pull-down and strong pull-up of a pin are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 latch, 1 high mode bits, 2 low mode bits |
| wr_data | input | 8 | Write data, one bit per pin |
| pin_in | input | 8 | Resolved pin levels |
| pull_dn_en | output | 8 | Pull-down enable per pin |
| strong_up_en | output | 8 | Strong pull-up enable per pin |
| weak_up_en | output | 8 | Weak pull-up enable per pin |
| vweak_up_en | output | 8 | Very-weak pull-up enable per pin |
| pin_rd | output | 8 | Synchronized pin levels |

## Verification
A corrupted latch or mode bit shows up on the enables in the first cycle after the bad edge. The most visible sign is a pull-down on a pin that should pull up, or a pin left undriven. A burst counter that loads wrongly or does not unload shows as a strong pull-up lasting one, three or more cycles, or staying on after a mode change. It also shows as a strong pull-up that overlaps the pull-down. A synchronizer with the wrong depth moves both pin_rd and the weak pull-up by a whole cycle relative to pin_in.

// File: rtl/gpio_drv_pkg.sv
package gpio_drv_pkg;

  typedef enum logic [1:0] {
    MODE_QUASI    = 2'b00,
    MODE_PUSHPULL = 2'b01,
    MODE_HIZ      = 2'b10,
    MODE_OPENDR   = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_LATCH   = 2'd0,
    SEL_MODE_HI = 2'd1,
    SEL_MODE_LO = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pull_dn;
    logic strong_up;
    logic weak_up;
    logic vweak_up;
  } drive_t;

  // Applies the per-pin restrictions to the raw mode bits.
  function automatic pin_mode_e resolve_mode(input logic m_hi, input logic m_lo,
                                             input logic hiz_only, input logic od_only);
    logic [1:0] code;
    code = {m_hi | od_only, m_lo};
    if (hiz_only) code = MODE_HIZ;
    return pin_mode_e'(code);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_drv_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] latch_q,
  output logic [NUM_PINS-1:0] mode_hi_q,
  output logic [NUM_PINS-1:0] mode_lo_q,
  output logic [NUM_PINS-1:0] latch_d,
  output logic [NUM_PINS-1:0] mode_hi_d,
  output logic [NUM_PINS-1:0] mode_lo_d
);

  logic wr_latch, wr_hi, wr_lo;

  always_comb begin
    wr_latch  = wr_en && (wr_sel == SEL_LATCH);
    wr_hi     = wr_en && (wr_sel == SEL_MODE_HI);
    wr_lo     = wr_en && (wr_sel == SEL_MODE_LO);
    latch_d   = wr_latch ? wr_data : latch_q;
    mode_hi_d = wr_hi    ? wr_data : mode_hi_q;
    mode_lo_d = wr_lo    ? wr_data : mode_lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '1;
      mode_hi_q <= '1;
      mode_lo_q <= '0;
    end else begin
      latch_q   <= latch_d;
      mode_hi_q <= mode_hi_d;
      mode_lo_q <= mode_lo_d;
    end
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_drv_pkg::*;
#(
  parameter int   PULSE_LEN = 2,
  parameter logic HIZ_ONLY  = 1'b0,
  parameter logic OD_ONLY   = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      latch_q,
  input  logic      latch_d,
  input  logic      mode_hi_q,
  input  logic      mode_lo_q,
  input  logic      mode_hi_d,
  input  logic      mode_lo_d,
  input  logic      pin_sync,
  output drive_t    drive,
  output pin_mode_e mode
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  pin_mode_e       mode_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            rise;

  always_comb begin
    mode     = resolve_mode(mode_hi_q, mode_lo_q, HIZ_ONLY, OD_ONLY);
    mode_nxt = resolve_mode(mode_hi_d, mode_lo_d, HIZ_ONLY, OD_ONLY);
    rise     = latch_d && !latch_q;
  end

  // Strong pull-up burst counter
  always_comb begin
    if (!latch_d || mode_nxt != MODE_QUASI) cnt_d = '0;
    else if (rise)                           cnt_d = CNT_LOAD;
    else if (cnt_q != '0)                    cnt_d = cnt_q - 1'b1;
    else                                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    drive = '0;
    unique case (mode)
      MODE_QUASI: begin
        drive.pull_dn   = !latch_q;
        drive.vweak_up  = latch_q;
        drive.weak_up   = latch_q && pin_sync;
        drive.strong_up = (cnt_q != '0);
      end
      MODE_PUSHPULL: begin
        drive.pull_dn   = !latch_q;
        drive.strong_up = latch_q;
      end
      MODE_OPENDR: drive.pull_dn = !latch_q;
      default:     drive = '0;
    endcase
  end

endmodule

// File: rtl/gpio_drive_ctrl.sv
module gpio_drive_ctrl
  import gpio_drv_pkg::*;
#(
  parameter int                  NUM_PINS      = 8,
  parameter int                  SYNC_STAGES   = 2,
  parameter int                  PULSE_LEN     = 2,
  parameter logic [NUM_PINS-1:0] HIZ_ONLY_MASK = 8'h20,
  parameter logic [NUM_PINS-1:0] OD_ONLY_MASK  = 8'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pull_dn_en,
  output logic [NUM_PINS-1:0] strong_up_en,
  output logic [NUM_PINS-1:0] weak_up_en,
  output logic [NUM_PINS-1:0] vweak_up_en,
  output logic [NUM_PINS-1:0] pin_rd
);

  logic [NUM_PINS-1:0]   latch_q, latch_d, hi_q, hi_d, lo_q, lo_d;
  logic [NUM_PINS-1:0]   pin_sync;
  logic [2*NUM_PINS-1:0] eff_mode;

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .latch_q(latch_q), .mode_hi_q(hi_q), .mode_lo_q(lo_q),
    .latch_d(latch_d), .mode_hi_d(hi_d), .mode_lo_d(lo_d)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    drive_t    drv;
    pin_mode_e pm;
    gpio_pin_drive #(
      .PULSE_LEN(PULSE_LEN),
      .HIZ_ONLY(HIZ_ONLY_MASK[p]),
      .OD_ONLY(OD_ONLY_MASK[p])
    ) u_drv (
      .clk(clk), .rst_n(rst_n),
      .latch_q(latch_q[p]), .latch_d(latch_d[p]),
      .mode_hi_q(hi_q[p]), .mode_lo_q(lo_q[p]),
      .mode_hi_d(hi_d[p]), .mode_lo_d(lo_d[p]),
      .pin_sync(pin_sync[p]), .drive(drv), .mode(pm)
    );
    assign pull_dn_en[p]       = drv.pull_dn;
    assign strong_up_en[p]     = drv.strong_up;
    assign weak_up_en[p]       = drv.weak_up;
    assign vweak_up_en[p]      = drv.vweak_up;
    assign eff_mode[2*p +: 2]  = pm;
  end

  assign pin_rd = pin_sync;

endmodule

// File: rtl/gpio_drive_ctrl_chk.sv
module gpio_drive_ctrl_chk #(
  parameter int                  NUM_PINS      = 8,
  parameter logic [NUM_PINS-1:0] HIZ_ONLY_MASK = 8'h20,
  parameter logic [NUM_PINS-1:0] OD_ONLY_MASK  = 8'h0C
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   pull_dn_en,
  input logic [NUM_PINS-1:0]   strong_up_en,
  input logic [NUM_PINS-1:0]   weak_up_en,
  input logic [NUM_PINS-1:0]   vweak_up_en,
  input logic [2*NUM_PINS-1:0] eff_mode
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic quasi, hiz;
    assign quasi = (eff_mode[2*p +: 2] == 2'b00);
    assign hiz   = (eff_mode[2*p +: 2] == 2'b10);

    AST_PD_STRONG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pull_dn_en[p] && strong_up_en[p])); // R12
    AST_WEAK_NEEDS_VWEAK: assert property (@(posedge clk) disable iff (!rst_n)
      weak_up_en[p] |-> (quasi && vweak_up_en[p])); // R4
    AST_VWEAK_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
      vweak_up_en[p] |-> !pull_dn_en[p]); // R3
    AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      hiz |-> !(pull_dn_en[p] || strong_up_en[p] || weak_up_en[p] || vweak_up_en[p])); // R8
    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (quasi && $past(quasi) && $past(quasi, 2) && $past(strong_up_en[p]) &&
       $past(strong_up_en[p], 2)) |-> !strong_up_en[p]); // R5
    if (HIZ_ONLY_MASK[p]) begin : g_hiz
      AST_HIZ_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_dn_en[p] || strong_up_en[p] || weak_up_en[p] || vweak_up_en[p])); // R9
    end
    if (OD_ONLY_MASK[p]) begin : g_od
      AST_OD_PIN_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        !(strong_up_en[p] || weak_up_en[p] || vweak_up_en[p])); // R10
    end
  end

endmodule

bind gpio_drive_ctrl gpio_drive_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .HIZ_ONLY_MASK(HIZ_ONLY_MASK), .OD_ONLY_MASK(OD_ONLY_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pull_dn_en(pull_dn_en), .strong_up_en(strong_up_en),
  .weak_up_en(weak_up_en), .vweak_up_en(vweak_up_en), .eff_mode(eff_mode)
);

// File: tb/gpio_drive_ctrl_test.sv
module gpio_drive_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] HIZ_PINS = 8'h20;
  localparam logic [7:0] OD_PINS  = 8'h0C;

  logic       clk, rst_n, wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data, pin_in;
  logic [7:0] pull_dn_en, strong_up_en, weak_up_en, vweak_up_en, pin_rd;

  int n_checks = 0;
  int n_fail   = 0;

  // Requirement model state
  logic [7:0] m_latch, m_hi, m_lo, m_s1, m_s2;
  int         m_cnt [8];

  gpio_drive_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pin_in(pin_in), .pull_dn_en(pull_dn_en), .strong_up_en(strong_up_en),
    .weak_up_en(weak_up_en), .vweak_up_en(vweak_up_en), .pin_rd(pin_rd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] exp_mode(int i, logic hi, logic lo);
    if (HIZ_PINS[i]) return 2'b10;
    return {hi | OD_PINS[i], lo};
  endfunction

  // {pull_dn, strong, weak, vweak}
  function automatic logic [3:0] exp_drv(int i);
    logic l;
    l = m_latch[i];
    case (exp_mode(i, m_hi[i], m_lo[i]))
      2'b00:   return {!l, m_cnt[i] != 0, l & m_s2[i], l};
      2'b01:   return {!l, l, 1'b0, 1'b0};
      2'b11:   return {!l, 3'b000};
      default: return 4'b0000;
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [7:0] e_pd, e_st, e_wk, e_vw;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] d;
      d = exp_drv(i);
      {e_pd[i], e_st[i], e_wk[i], e_vw[i]} = d;
    end
    cmp(tag, "pull_dn_en",   pull_dn_en,   e_pd);
    cmp(tag, "strong_up_en", strong_up_en, e_st);
    cmp(tag, "weak_up_en",   weak_up_en,   e_wk);
    cmp(tag, "vweak_up_en",  vweak_up_en,  e_vw);
    cmp(tag, "pin_rd",       pin_rd,       m_s2);
  endtask

  // Drive at negedge, advance one edge, update model, check at next negedge.
  task automatic step(string tag, logic we, logic [1:0] sel, logic [7:0] data, logic [7:0] pins);
    logic [7:0] nl, nh, nlo;
    wr_en = we; wr_sel = sel; wr_data = data; pin_in = pins;
    @(posedge clk);
    nl  = (we && sel == 2'd0) ? data : m_latch;
    nh  = (we && sel == 2'd1) ? data : m_hi;
    nlo = (we && sel == 2'd2) ? data : m_lo;
    for (int i = 0; i < 8; i++) begin
      if (!nl[i] || exp_mode(i, nh[i], nlo[i]) != 2'b00) m_cnt[i] = 0;
      else if (!m_latch[i])                              m_cnt[i] = 2;
      else if (m_cnt[i] != 0)                            m_cnt[i] = m_cnt[i] - 1;
    end
    m_latch = nl; m_hi = nh; m_lo = nlo;
    m_s2 = m_s1; m_s1 = pins;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, 1'b0, 2'd3, 8'h00, pin_in);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; pin_in = '0;
    m_latch = '1; m_hi = '1; m_lo = '0; m_s1 = '0; m_s2 = '0;
    for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 / R9 / R10: all pins quasi; pin 5 stays idle, pins 2,3 become inputs
    step("R2", 1'b1, 2'd1, 8'h00, 8'hFF);
    step("R9", 1'b0, 2'd3, 8'h00, 8'hFF);
    step("R11", 1'b0, 2'd3, 8'h00, 8'hFF);
    step("R4", 1'b1, 2'd3, 8'hAA, 8'h0F);  // sel 3 writes nothing
    idle("R4", 2);
    // R3 latch low, then rise -> burst
    step("R3", 1'b1, 2'd0, 8'h00, 8'hF0);
    step("R5", 1'b1, 2'd0, 8'hFF, 8'hF0);
    idle("R5", 3);
    // R5: rise on some pins only
    step("R5", 1'b1, 2'd0, 8'h0F, 8'hF0);
    step("R5", 1'b1, 2'd0, 8'hFF, 8'hF0);
    idle("R5", 2);
    // R6: burst cancelled by mode change
    step("R6", 1'b1, 2'd0, 8'h00, 8'h00);
    step("R6", 1'b1, 2'd0, 8'hFF, 8'h00);
    step("R6", 1'b1, 2'd1, 8'hFF, 8'h00);
    idle("R6", 2);
    step("R6", 1'b1, 2'd1, 8'h00, 8'h00);
    // R6: burst cancelled by latch clear
    step("R6", 1'b1, 2'd0, 8'h00, 8'h00);
    step("R6", 1'b1, 2'd0, 8'hFF, 8'h00);
    step("R6", 1'b1, 2'd0, 8'h00, 8'h00);
    idle("R6", 2);
    // R10 / R7: push-pull everywhere; pins 2,3 become open drain
    step("R10", 1'b1, 2'd2, 8'hFF, 8'h00);
    step("R7", 1'b1, 2'd0, 8'h5A, 8'h00);
    step("R7", 1'b1, 2'd0, 8'hA5, 8'h33);
    // R8: open drain, then hi-z
    step("R8", 1'b1, 2'd1, 8'hFF, 8'h33);
    step("R8", 1'b1, 2'd0, 8'h3C, 8'h33);
    step("R8", 1'b1, 2'd2, 8'h00, 8'h33);
    // R11: single pin edge delay
    step("R11", 1'b0, 2'd3, 8'h00, 8'h01);
    idle("R11", 2);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] s;
      logic [7:0] d, p;
      s = 2'($urandom % 4);
      d = 8'($urandom);
      if (s == 2'd1) d = d & 8'($urandom);
      p = ($urandom % 4 == 0) ? 8'($urandom) : pin_in;
      step("R12", ($urandom % 3) != 0, s, d, p);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule